// File: doc/BRIEF.md
# Clocked Host Bus Slave with Wait-State Hold-Off

This block is the bus-facing end of a 16-bit host port that runs on the host's bus clock. On every rising clock edge it samples a chip select, a word address, a memory/register select flag and two byte-lane strobes for each direction. A host access begins at the first edge where the chip select and at least one strobe are active. The block captures the address, the access kind and the byte enables on that edge. It captures write data two edges later, on the third edge of the access.

The block then issues a request on an internal request/acknowledge port. While the access is in progress it holds the host off with a wait signal. The wait signal is modelled as an output enable plus a driven value, in the manner of an open-drain line. It is pulled low from the first edge until two conditions hold:

- the internal side has acknowledged the request;
- a minimum strobe length has elapsed. This minimum is 13, 18, 23 or 28 clocks, chosen by a 2-bit memory-clock divider select.

The block then drives the wait line high, and read data is valid on the data bus. Once the host removes all strobes, the block stops driving the wait line and the read data. This leaves the wait line undriven (high impedance) whenever no access is under way. Byte-lane strobes become byte enables: lane 0 covers bits 7:0 and lane 1 covers bits 15:8.

The controller has five states:

- IDLE: no access.
- ADDR_TAKEN: the first edge has been seen.
- DATA_PEND: waiting for the write-data edge.
- ACCESS: the internal request is outstanding, or the minimum time is still running.
- RELEASE: the wait line is high and the block waits for the strobes to lift.

The transitions are:

- START: IDLE to ADDR_TAKEN, when the chip select and any strobe are active.
- STEP: ADDR_TAKEN to DATA_PEND, unconditionally.
- LATCH: DATA_PEND to ACCESS, unconditionally; this edge captures the write data.
- GRANT: ACCESS to RELEASE, once the acknowledge has been seen and the minimum count is met.
- END: RELEASE to IDLE, when all strobes are inactive.

Top module: `hbus_wait_slave`

## Requirements
- R1: After reset the wait output enable, the read data enable and the internal request are all 0.
- R2: An access starts only at an edge where host_cs_n is 0 and at least one of host_rd_n/host_wr_n is 0. From the following cycle, host_wait_oe is 1 and host_wait_val is 0. While host_cs_n is 1, active strobes start nothing.
- R3: int_wdata holds the bus value sampled on the third rising edge of the access. Changes on host_wdata before or after that edge are not captured.
- R4: int_req rises after the third edge and stays high until the edge where int_ack is sampled high. It is low in the cycle after that edge.
- R5: The wait line stays driven low for exactly max(13 + 5*clk_div_sel, 2 + L) cycles. Here L is the number of cycles from int_req rising to the edge that samples int_ack, so the acknowledge arriving at edge 3+L gives latency L.
- R6: On release, host_wait_oe stays 1 with host_wait_val 1 while any strobe is low. After the first edge where all strobes are high, host_wait_oe and host_rdata_oe are both 0.
- R7: For a read, host_rdata_oe is 1 from the cycle after the start edge until release. Once host_wait_val is 1, host_rdata equals the acknowledged int_rdata, with disabled byte lanes reading 0.
- R8: Strobe bit 0 enables bits 7:0 and bit 1 enables bits 15:8. int_be reflects the active lanes. Lanes that are not enabled are 0 in both the write buffer and the returned read data. If write and read strobes are both active, the access is a write.
- R9: While the strobes stay low after release, no new access starts. The wait line stays driven high and int_req stays low.
- R10: Address, memory/register select and direction are taken on the start edge. int_addr, int_mem and int_write keep these values even if the host lines change later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Chip select, active low |
| host_addr | input | 18 | Word address (address bits 18:1) |
| host_mem_sel | input | 1 | 1 = memory space, 0 = register space |
| host_rd_n | input | 2 | Byte-lane read strobes, active low |
| host_wr_n | input | 2 | Byte-lane write strobes, active low |
| host_wdata | input | 16 | Write data from the host |
| host_rdata | output | 16 | Read data to the host |
| host_rdata_oe | output | 1 | Read data bus drive enable |
| host_wait_oe | output | 1 | Wait line drive enable (0 = high impedance) |
| host_wait_val | output | 1 | Wait line level when driven (0 = hold off) |
| clk_div_sel | input | 2 | Memory-clock divide select (0..3 for divide by 1..4) |
| int_req | output | 1 | Internal access request |
| int_write | output | 1 | Internal access is a write |
| int_mem | output | 1 | Internal access targets memory space |
| int_addr | output | 18 | Internal access word address |
| int_be | output | 2 | Internal byte enables |
| int_wdata | output | 16 | Internal write data (write buffer) |
| int_ack | input | 1 | Internal acknowledge, sampled while int_req is high |
| int_rdata | input | 16 | Internal read data, valid with int_ack |

## Verification
Two release paths are hard to steer from the ports: the acknowledge arriving before the minimum count expires, and arriving after it. The exact tie, where both conditions are met on the same edge, is hardest of all. The bench's responder sets the acknowledge latency for each access. Directed cases choose latencies below, equal to and well above the divider's minimum (for example divide-by-2 with latency 16). Random accesses spread latency and divider widely. The bench also changes the write data and address lines on edges other than the capture edges, to show which edge is the one captured.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_TAKEN,
        ST_DATA_PEND,
        ST_ACCESS,
        ST_RELEASE
    } bus_state_t;

endpackage

// File: rtl/hbus_strobe_decode.sv
module hbus_strobe_decode #(
    parameter int LANES = 2
) (
    input  logic             cs_n,
    input  logic [LANES-1:0] rd_n,
    input  logic [LANES-1:0] wr_n,
    output logic             any_low,
    output logic             start_ok,
    output logic             is_write,
    output logic [LANES-1:0] lane_en
);

    always_comb begin
        any_low  = (~&rd_n) || (~&wr_n);
        start_ok = !cs_n && any_low;
        is_write = ~&wr_n;
        lane_en  = is_write ? ~wr_n : ~rd_n;
    end

endmodule

// File: rtl/hbus_len_timer.sv
module hbus_len_timer #(
    parameter int BASE_LEN = 13,
    parameter int STEP_LEN = 5,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEL_W-1:0] div_sel,
    output logic             met
);

    localparam int MAX_LEN = BASE_LEN + STEP_LEN * ((1 << SEL_W) - 1);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            limit <= CNT_W'(BASE_LEN);
        end else if (start) begin
            cnt   <= CNT_W'(1);
            limit <= CNT_W'(BASE_LEN) + CNT_W'(STEP_LEN) * CNT_W'(div_sel);
        end else if (cnt < CNT_W'(MAX_LEN)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign met = (cnt >= limit);

endmodule

// File: rtl/hbus_data_path.sv
module hbus_data_path #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_addr,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic                mem_in,
    input  logic                write_in,
    input  logic [DATA_W/8-1:0] be_in,
    input  logic                take_wdata,
    input  logic [DATA_W-1:0]   wdata_in,
    input  logic                take_rdata,
    input  logic [DATA_W-1:0]   rdata_in,
    output logic [ADDR_W-1:0]   addr_q,
    output logic                mem_q,
    output logic                write_q,
    output logic [DATA_W/8-1:0] be_q,
    output logic [DATA_W-1:0]   wbuf_q,
    output logic [DATA_W-1:0]   rbuf_q
);

    localparam int LANES = DATA_W / 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            mem_q   <= 1'b0;
            write_q <= 1'b0;
            be_q    <= '0;
        end else if (take_addr) begin
            addr_q  <= addr_in;
            mem_q   <= mem_in;
            write_q <= write_in;
            be_q    <= be_in;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wbuf_q[g*8 +: 8] <= '0;
                rbuf_q[g*8 +: 8] <= '0;
            end else begin
                if (take_wdata)
                    wbuf_q[g*8 +: 8] <= be_q[g] ? wdata_in[g*8 +: 8] : 8'h00;
                if (take_addr)
                    rbuf_q[g*8 +: 8] <= 8'h00;
                else if (take_rdata)
                    rbuf_q[g*8 +: 8] <= be_q[g] ? rdata_in[g*8 +: 8] : 8'h00;
            end
        end
    end

endmodule

// File: rtl/hbus_wait_slave.sv
module hbus_wait_slave
    import hbus_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 18,
    parameter int SEL_W    = 2,
    parameter int BASE_LEN = 13,
    parameter int STEP_LEN = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_cs_n,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic                host_mem_sel,
    input  logic [DATA_W/8-1:0] host_rd_n,
    input  logic [DATA_W/8-1:0] host_wr_n,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                host_rdata_oe,
    output logic                host_wait_oe,
    output logic                host_wait_val,
    input  logic [SEL_W-1:0]    clk_div_sel,
    output logic                int_req,
    output logic                int_write,
    output logic                int_mem,
    output logic [ADDR_W-1:0]   int_addr,
    output logic [DATA_W/8-1:0] int_be,
    output logic [DATA_W-1:0]   int_wdata,
    input  logic                int_ack,
    input  logic [DATA_W-1:0]   int_rdata
);

    localparam int LANES = DATA_W / 8;

    bus_state_t       state, nxt;
    logic             ack_seen;
    logic             any_low, start_ok, is_write;
    logic [LANES-1:0] lane_en;
    logic             len_met;
    logic             start_evt, granted;

    hbus_strobe_decode #(.LANES(LANES)) i_decode (
        .cs_n     (host_cs_n),
        .rd_n     (host_rd_n),
        .wr_n     (host_wr_n),
        .any_low  (any_low),
        .start_ok (start_ok),
        .is_write (is_write),
        .lane_en  (lane_en)
    );

    assign start_evt = (state == ST_IDLE) && start_ok;

    hbus_len_timer #(
        .BASE_LEN (BASE_LEN),
        .STEP_LEN (STEP_LEN),
        .SEL_W    (SEL_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_evt),
        .div_sel (clk_div_sel),
        .met     (len_met)
    );

    hbus_data_path #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) i_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_addr  (start_evt),
        .addr_in    (host_addr),
        .mem_in     (host_mem_sel),
        .write_in   (is_write),
        .be_in      (lane_en),
        .take_wdata ((state == ST_DATA_PEND) && int_write),
        .wdata_in   (host_wdata),
        .take_rdata (int_req && int_ack && !int_write),
        .rdata_in   (int_rdata),
        .addr_q     (int_addr),
        .mem_q      (int_mem),
        .write_q    (int_write),
        .be_q       (int_be),
        .wbuf_q     (int_wdata),
        .rbuf_q     (host_rdata)
    );

    assign granted = ack_seen || (int_req && int_ack);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ack_seen <= 1'b0;
        end else begin
            state    <= nxt;
            ack_seen <= (state == ST_ACCESS) && granted && (nxt == ST_ACCESS);
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (start_ok) nxt = ST_ADDR_TAKEN;
            ST_ADDR_TAKEN: nxt = ST_DATA_PEND;
            ST_DATA_PEND:  nxt = ST_ACCESS;
            ST_ACCESS:     if (granted && len_met) nxt = ST_RELEASE;
            ST_RELEASE:    if (!any_low) nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        host_wait_oe  = 1'b1;
        host_wait_val = 1'b0;
        host_rdata_oe = !int_write;
        int_req       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                host_wait_oe  = 1'b0;
                host_wait_val = 1'b1;
                host_rdata_oe = 1'b0;
            end
            ST_ADDR_TAKEN, ST_DATA_PEND: ;
            ST_ACCESS:  int_req = !ack_seen;
            ST_RELEASE: host_wait_val = 1'b1;
            default: begin
                host_wait_oe  = 1'b0;
                host_rdata_oe = 1'b0;
            end
        endcase
    end

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wait_oe && !host_cs_n && any_low) |=> (host_wait_oe && !host_wait_val));

    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack) |=> !int_req);

    p_wdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && $past(int_req)) |-> $stable(int_wdata));

    p_min_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wait_oe && !host_wait_val) |=> (host_wait_val ? len_met : 1'b1));

    p_release_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wait_oe && host_wait_val && !any_low) |=> (!host_wait_oe && !host_rdata_oe));

    p_hold_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wait_oe && host_wait_val && any_low) |=> (host_wait_oe && host_wait_val && !int_req));

    p_attr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wait_oe && $past(host_wait_oe)) |-> ($stable(int_addr) && $stable(int_write) && $stable(int_mem)));

endmodule

// File: tb/test_hbus_wait_slave.sv
module test_hbus_wait_slave;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs_n = 1'b1;
    logic [17:0] host_addr = '0;
    logic        host_mem_sel = 1'b0;
    logic [1:0]  host_rd_n = 2'b11;
    logic [1:0]  host_wr_n = 2'b11;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rdata_oe, host_wait_oe, host_wait_val;
    logic [1:0]  clk_div_sel = '0;
    logic        int_req, int_write, int_mem;
    logic [17:0] int_addr;
    logic [1:0]  int_be;
    logic [15:0] int_wdata;
    logic        int_ack = 1'b0;
    logic [15:0] int_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int resp_lat = 1;
    logic [15:0] resp_data = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbus_wait_slave i_hbus_wait_slave (
        .clk, .rst_n, .host_cs_n, .host_addr, .host_mem_sel, .host_rd_n,
        .host_wr_n, .host_wdata, .host_rdata, .host_rdata_oe, .host_wait_oe,
        .host_wait_val, .clk_div_sel, .int_req, .int_write, .int_mem,
        .int_addr, .int_be, .int_wdata, .int_ack, .int_rdata
    );

    // internal responder: acknowledge after resp_lat cycles of request
    initial begin
        int rc;
        rc = 0;
        forever begin
            @(negedge clk);
            if (int_ack) begin
                int_ack = 1'b0;
                rc = 0;
            end else if (int_req) begin
                rc++;
                if (rc == resp_lat) begin
                    int_ack   = 1'b1;
                    int_rdata = resp_data;
                end
            end else begin
                rc = 0;
            end
        end
    end

    function automatic logic [15:0] lane_mask(logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic int exp_low(logic [1:0] div, int lat);
        int m;
        m = 13 + 5 * int'(div);
        return (m > 2 + lat) ? m : 2 + lat;
    endfunction

    task automatic check(bit ok, string rq, string msg);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", rq, msg);
        end
    endtask

    task automatic run_cycle(bit wr, logic [1:0] be, logic [17:0] addr, bit mem,
                             logic [15:0] data, logic [1:0] div, int lat, int hold);
        int low;
        int guard;
        @(negedge clk);
        clk_div_sel  = div;
        host_addr    = addr;
        host_mem_sel = mem;
        host_wdata   = ~data;
        resp_lat     = lat;
        resp_data    = data ^ 16'h5AC3;
        host_cs_n    = 1'b0;
        if (wr) host_wr_n = ~be; else host_rd_n = ~be;
        @(negedge clk);  // after edge 1
        check(host_wait_oe && !host_wait_val, "R2",
              $sformatf("oe=%0b val=%0b exp 1/0", host_wait_oe, host_wait_val));
        check(host_rdata_oe == !wr, "R7",
              $sformatf("rdata_oe=%0b exp %0b", host_rdata_oe, !wr));
        low = 1;
        host_addr    = ~addr;
        host_mem_sel = !mem;
        @(negedge clk);  // after edge 2
        if (host_wait_oe && !host_wait_val) low++;
        host_wdata = data;
        @(negedge clk);  // after edge 3
        if (host_wait_oe && !host_wait_val) low++;
        host_wdata = $urandom();
        check(int_req == 1'b1, "R4", $sformatf("req=%0b exp 1", int_req));
        guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if (host_wait_oe && !host_wait_val && guard < 300) low++;
            else break;
        end
        check(low == exp_low(div, lat), "R5",
              $sformatf("low cycles=%0d exp %0d (div=%0d lat=%0d)", low, exp_low(div, lat), div, lat));
        check(host_wait_oe && host_wait_val && !int_req, "R6",
              $sformatf("oe=%0b val=%0b req=%0b exp 1/1/0", host_wait_oe, host_wait_val, int_req));
        check(int_addr == addr && int_mem == mem && int_write == wr, "R10",
              $sformatf("addr=%h mem=%0b wr=%0b exp %h %0b %0b", int_addr, int_mem, int_write, addr, mem, wr));
        check(int_be == be, "R8", $sformatf("be=%b exp %b", int_be, be));
        if (wr)
            check(int_wdata == (data & lane_mask(be)), "R3",
                  $sformatf("wbuf=%h exp %h", int_wdata, data & lane_mask(be)));
        else
            check(host_rdata_oe && host_rdata == (resp_data & lane_mask(be)), "R7",
                  $sformatf("rdata=%h oe=%0b exp %h", host_rdata, host_rdata_oe, resp_data & lane_mask(be)));
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(host_wait_oe && host_wait_val && !int_req, "R9",
                  $sformatf("oe=%0b val=%0b req=%0b exp 1/1/0", host_wait_oe, host_wait_val, int_req));
        end
        host_rd_n = 2'b11;
        host_wr_n = 2'b11;
        host_cs_n = 1'b1;
        @(negedge clk);
        check(!host_wait_oe && !host_rdata_oe, "R6",
              $sformatf("after release oe=%0b rdata_oe=%0b exp 0/0", host_wait_oe, host_rdata_oe));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(!host_wait_oe && !host_rdata_oe && !int_req, "R1",
              $sformatf("in reset oe=%0b rdoe=%0b req=%0b exp 0", host_wait_oe, host_rdata_oe, int_req));
        rst_n = 1'b1;
        @(negedge clk);
        check(!host_wait_oe && !host_rdata_oe && !int_req, "R1",
              $sformatf("after reset oe=%0b rdoe=%0b req=%0b exp 0", host_wait_oe, host_rdata_oe, int_req));

        // R2: strobes active with chip select inactive start nothing
        host_rd_n = 2'b00;
        repeat (4) begin
            @(negedge clk);
            check(!host_wait_oe && !int_req, "R2",
                  $sformatf("cs high oe=%0b req=%0b exp 0/0", host_wait_oe, int_req));
        end
        host_rd_n = 2'b11;

        run_cycle(1, 2'b11, 18'h2A5F1, 1, 16'hBEEF, 2'd0, 1, 0);
        run_cycle(1, 2'b01, 18'h00010, 0, 16'h1234, 2'd3, 40, 0);
        run_cycle(1, 2'b10, 18'h3FFFF, 1, 16'hA55A, 2'd1, 3, 2);
        run_cycle(0, 2'b10, 18'h12345, 1, 16'hC0DE, 2'd2, 5, 0);
        run_cycle(0, 2'b11, 18'h0ABCD, 0, 16'h7E81, 2'd1, 16, 3);  // tie
        run_cycle(0, 2'b01, 18'h1F0F0, 1, 16'hFFFF, 2'd3, 26, 0);  // tie

        // R8: write and read strobes together count as a write
        host_rd_n = 2'b00;
        run_cycle(1, 2'b01, 18'h00777, 1, 16'h9966, 2'd0, 2, 0);

        for (int k = 0; k < 40; k++) begin
            run_cycle(1'($urandom_range(0, 1)), 2'($urandom_range(1, 3)), 18'($urandom()),
                      1'($urandom_range(0, 1)), 16'($urandom()), 2'($urandom_range(0, 3)),
                      int'($urandom_range(1, 32)), int'($urandom_range(0, 2)));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule